// File: doc/BRIEF.md
# Two-Wire Slave Command Front End

This block is the serial front end of a small register bank that sets a tap position. It watches a two-wire bus (clock line and data line) with the system clock and recognises start and stop conditions. It accepts transactions addressed to it and turns them into decoded commands for the bank. It answers by pulling the data line low through an open-drain enable. It never drives the line high.

A transaction begins with an address byte, followed by an instruction byte that carries a 4-bit opcode and a 2-bit register select. What follows depends on the opcode. A write takes one more byte from the master. A read returns one byte to the master. A transfer needs no further byte. The step opcode turns the bus into a bit-serial stream in which every clock pulse moves the tap one position up or down, until the master sends a stop.

Commands that change state are handed to the bank only when the stop arrives, so a transaction cut short by a new start has no effect. Read data is fetched from the bank in the same cycle as the read select is shown to it, with no request handshake.

Top module: `twowire_cmd_slave`

## Requirements
- R1: SCL and SDA each pass through a two-flop synchroniser. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both are detected at any point, and the line is idle high after reset.
- R2: The first byte after a start is taken MSB first and must equal {4'b0101, dev_pins[2], dev_pins[1], 1'b0, dev_pins[0]}. On any mismatch, including bit 1 set, no ACK is given and the bus is ignored until the next start or stop.
- R3: After a matching address byte, an accepted instruction byte and a write data byte, the block drives sda_pull high during the ninth clock. It asserts sda_pull only after an SCL falling edge and releases it after the falling edge that ends the ninth clock. After reset, sda_pull is 0.
- R4: In the instruction byte, bits 7..4 are the opcode and bits 3..2 are the register select. The accepted opcodes are 1001 read tap, 1010 write tap, 1011 read store, 1100 write store, 1101 store-to-tap, 1110 tap-to-store and 0010 step. Any other opcode gets no ACK, and the bus is then ignored until the next start.
- R5: For 1010 and 1100, the low six bits of the third byte become cmd_data. For these two and for the transfers 1101 and 1110, cmd_valid pulses for one cycle after the stop, with cmd_op holding the opcode and cmd_sel the select.
- R6: For 1001 and 1011, rd_wiper (1 for opcode 1001) and rd_sel are shown to the bank. After the instruction ACK the block shifts out {2'b00, rd_data} MSB first, changing bits after SCL falls. It then releases SDA for the master's acknowledge. A read issues no cmd_valid.
- R7: After a step instruction is acknowledged, each SCL pulse with SDA high gives one step_up pulse, and each pulse with SDA low gives one step_dn pulse. The pulse comes after the SCL falling edge. The partial clock that ends in a stop gives no step, and step_up and step_dn are never high together.
- R8: A start in the middle of a transaction drops any command that has not yet been issued and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| dev_pins | input | 3 | Strapped address bits {A3, A2, A0} |
| rd_data | input | 6 | Value read from the bank for the shown select |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| rd_sel | output | 2 | Register select of the current instruction |
| rd_wiper | output | 1 | 1 when the current read targets the tap register |
| cmd_valid | output | 1 | One-cycle command strobe after stop |
| cmd_op | output | 4 | Opcode of the issued command |
| cmd_sel | output | 2 | Register select of the issued command |
| cmd_data | output | 6 | Write value of the issued command |
| step_up | output | 1 | One-cycle pulse: move tap up one position |
| step_dn | output | 1 | One-cycle pulse: move tap down one position |

## Verification
The assertions assume a legal bus. SDA changes only while SCL is low, except for start and stop conditions. Every SCL phase lasts several system clocks, so the synchronised edges reach the control logic in order. The master never makes a start or a stop while the slave is pulling SDA low. The stimulus tasks hold each SCL phase for eight clocks and wait two clocks after every falling edge before SDA moves. They make starts and stops only from a released line.

// File: rtl/twc_pkg.sv
package twc_pkg;

    localparam int VAL_W = 6;
    localparam int SEL_W = 2;
    localparam int OP_W  = 4;

    localparam logic [OP_W-1:0] OP_STEP   = 4'b0010;
    localparam logic [OP_W-1:0] OP_RD_TAP = 4'b1001;
    localparam logic [OP_W-1:0] OP_WR_TAP = 4'b1010;
    localparam logic [OP_W-1:0] OP_RD_STO = 4'b1011;
    localparam logic [OP_W-1:0] OP_WR_STO = 4'b1100;
    localparam logic [OP_W-1:0] OP_STO2T  = 4'b1101;
    localparam logic [OP_W-1:0] OP_T2STO  = 4'b1110;

    typedef enum logic [3:0] {
        PH_IDLE, PH_ADDR, PH_ACK_A, PH_INSTR, PH_ACK_I,
        PH_WDATA, PH_ACK_W, PH_RDATA, PH_MACK, PH_STEP, PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [SEL_W-1:0] sel;
        logic [VAL_W-1:0] data;
    } cmd_t;

    function automatic logic [7:0] own_addr(input logic [2:0] pins);
        return {4'b0101, pins[2], pins[1], 1'b0, pins[0]};
    endfunction

    function automatic logic op_is_read(input logic [OP_W-1:0] op);
        return (op == OP_RD_TAP) || (op == OP_RD_STO);
    endfunction

    function automatic logic op_is_write(input logic [OP_W-1:0] op);
        return (op == OP_WR_TAP) || (op == OP_WR_STO);
    endfunction

    function automatic logic op_is_xfer(input logic [OP_W-1:0] op);
        return (op == OP_STO2T) || (op == OP_T2STO);
    endfunction

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return op_is_read(op) || op_is_write(op) || op_is_xfer(op) || (op == OP_STEP);
    endfunction

endpackage

// File: rtl/twc_sync.sv
module twc_sync
    import twc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_pin,
    input  logic     sda_pin,
    output bus_evt_t evt
);
    localparam int LINES = 2;

    logic [LINES-1:0]             pins;
    logic [LINES-1:0][STAGES-1:0] chain;
    logic [LINES-1:0]             now_l;
    logic [LINES-1:0]             prev_l;

    assign pins = {scl_pin, sda_pin};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= '1;
            else     chain[g] <= {chain[g][STAGES-2:0], pins[g]};
        end
        assign now_l[g] = chain[g][STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_l <= '1;
        else     prev_l <= now_l;
    end

    always_comb begin
        evt.scl   = now_l[1];
        evt.sda   = now_l[0];
        evt.rise  = now_l[1] & ~prev_l[1];
        evt.fall  = ~now_l[1] & prev_l[1];
        evt.start = now_l[1] & prev_l[1] & prev_l[0] & ~now_l[0];
        evt.stop  = now_l[1] & prev_l[1] & ~prev_l[0] & now_l[0];
    end

endmodule

// File: rtl/twc_stepper.sv
module twc_stepper
    import twc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  logic     active,
    output logic     step_up,
    output logic     step_dn
);
    logic armed;
    logic dir;

    always_ff @(posedge clk) begin
        if (rst || !active || evt.start || evt.stop) begin
            armed   <= 1'b0;
            dir     <= 1'b0;
            step_up <= 1'b0;
            step_dn <= 1'b0;
        end else begin
            step_up <= 1'b0;
            step_dn <= 1'b0;
            if (evt.rise) begin
                armed <= 1'b1;
                dir   <= evt.sda;
            end else if (evt.fall && armed) begin
                step_up <= dir;
                step_dn <= ~dir;
                armed   <= 1'b0;
            end
        end
    end

    AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(step_up && step_dn)); // R7
    AST_STEP_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        (step_up || step_dn) |-> $past(evt.fall)); // R7

endmodule

// File: rtl/twc_ctrl.sv
module twc_ctrl
    import twc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic [2:0]       dev_pins,
    input  logic [VAL_W-1:0] rd_data,
    output logic             sda_pull,
    output logic [SEL_W-1:0] rd_sel,
    output logic             rd_wiper,
    output logic             cmd_valid,
    output cmd_t             cmd,
    output logic             step_mode
);
    localparam logic [3:0] BYTE_END = 4'd8;

    phase_e          ph;
    logic [3:0]      nbit;
    logic [7:0]      rx;
    logic [7:0]      tx;
    logic [OP_W-1:0] op;
    logic [SEL_W-1:0] sel;
    logic [VAL_W-1:0] wval;
    logic            pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE; nbit <= '0; rx <= '0; tx <= '0;
            op <= '0; sel <= '0; wval <= '0; pend <= 1'b0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (evt.start) begin
                ph   <= PH_ADDR;
                nbit <= '0;
                pend <= 1'b0;
            end else if (evt.stop) begin
                ph        <= PH_IDLE;
                cmd_valid <= pend;
                pend      <= 1'b0;
            end else begin
                unique case (ph)
                    PH_ADDR, PH_INSTR, PH_WDATA: begin
                        if (evt.rise) begin
                            rx   <= {rx[6:0], evt.sda};
                            nbit <= nbit + 4'd1;
                        end else if (evt.fall && nbit == BYTE_END) begin
                            nbit <= '0;
                            if (ph == PH_ADDR) begin
                                ph <= (rx == own_addr(dev_pins)) ? PH_ACK_A : PH_SKIP;
                            end else if (ph == PH_INSTR) begin
                                if (op_known(rx[7:4])) begin
                                    ph  <= PH_ACK_I;
                                    op  <= rx[7:4];
                                    sel <= rx[3:2];
                                end else begin
                                    ph <= PH_SKIP;
                                end
                            end else begin
                                ph   <= PH_ACK_W;
                                wval <= rx[VAL_W-1:0];
                                pend <= 1'b1;
                            end
                        end
                    end
                    PH_ACK_A: if (evt.fall) ph <= PH_INSTR;
                    PH_ACK_I: if (evt.fall) begin
                        if (op_is_read(op)) begin
                            ph <= PH_RDATA;
                            tx <= {2'b00, rd_data};
                        end else if (op_is_write(op)) begin
                            ph <= PH_WDATA;
                        end else if (op_is_xfer(op)) begin
                            ph   <= PH_SKIP;
                            pend <= 1'b1;
                        end else begin
                            ph <= PH_STEP;
                        end
                    end
                    PH_ACK_W: if (evt.fall) ph <= PH_SKIP;
                    PH_RDATA: begin
                        if (evt.rise) begin
                            nbit <= nbit + 4'd1;
                        end else if (evt.fall) begin
                            if (nbit == BYTE_END) begin
                                ph   <= PH_MACK;
                                nbit <= '0;
                            end else begin
                                tx <= {tx[6:0], 1'b0};
                            end
                        end
                    end
                    PH_MACK: if (evt.fall) ph <= PH_SKIP;
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull  = (ph == PH_ACK_A) || (ph == PH_ACK_I) || (ph == PH_ACK_W)
                     || ((ph == PH_RDATA) && !tx[7]);
    assign rd_sel    = sel;
    assign rd_wiper  = (op == OP_RD_TAP);
    assign step_mode = (ph == PH_STEP);
    assign cmd       = '{op: op, sel: sel, data: wval};

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !evt.scl); // R3
    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(evt.fall)); // R3
    AST_NACK_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ADDR && evt.fall && nbit == BYTE_END && rx != own_addr(dev_pins))
        |=> !sda_pull); // R2
    AST_CMD_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(evt.stop)); // R5
    AST_START_ABORTS: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (ph == PH_ADDR && !pend)); // R8

endmodule

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave
    import twc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [2:0]       dev_pins,
    input  logic [VAL_W-1:0] rd_data,
    output logic             sda_pull,
    output logic [SEL_W-1:0] rd_sel,
    output logic             rd_wiper,
    output logic             cmd_valid,
    output logic [OP_W-1:0]  cmd_op,
    output logic [SEL_W-1:0] cmd_sel,
    output logic [VAL_W-1:0] cmd_data,
    output logic             step_up,
    output logic             step_dn
);
    bus_evt_t evt;
    cmd_t     cmd;
    logic     step_mode;

    twc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_pin(scl_in), .sda_pin(sda_in), .evt(evt)
    );

    twc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .evt(evt), .dev_pins(dev_pins), .rd_data(rd_data),
        .sda_pull(sda_pull), .rd_sel(rd_sel), .rd_wiper(rd_wiper),
        .cmd_valid(cmd_valid), .cmd(cmd), .step_mode(step_mode)
    );

    twc_stepper u_step (
        .clk(clk), .rst(rst), .evt(evt), .active(step_mode),
        .step_up(step_up), .step_dn(step_dn)
    );

    assign cmd_op   = cmd.op;
    assign cmd_sel  = cmd.sel;
    assign cmd_data = cmd.data;

endmodule

// File: tb/sim_twowire_cmd_slave.sv
module sim_twowire_cmd_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam logic [2:0] PINS = 3'b101;
    localparam logic [7:0] MY_ADDR = 8'h59;
    localparam logic [5:0] TAP_VAL = 6'h2B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic [5:0] rd_data;
    logic sda_pull, rd_wiper, cmd_valid, step_up, step_dn;
    logic [1:0] rd_sel, cmd_sel;
    logic [3:0] cmd_op;
    logic [5:0] cmd_data;

    int checks = 0;
    int fails = 0;
    int n_up = 0;
    int n_dn = 0;
    int quiet_viol = 0;
    logic expect_quiet = 1'b0;
    logic [11:0] cmd_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] store_val(input logic [1:0] s);
        return 6'(5 + 13 * int'(s));
    endfunction

    assign sda_line = sda_m & ~sda_pull;
    assign rd_data  = rd_wiper ? TAP_VAL : store_val(rd_sel);

    twowire_cmd_slave u0 (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .dev_pins(PINS),
        .rd_data(rd_data), .sda_pull(sda_pull), .rd_sel(rd_sel), .rd_wiper(rd_wiper),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
        .step_up(step_up), .step_dn(step_dn)
    );

    // every-clock monitor of outputs against the model's expectations
    always @(posedge clk) begin
        if (!rst) begin
            if (cmd_valid) cmd_q.push_back({cmd_op, cmd_sel, cmd_data});
            if (step_up) n_up++;
            if (step_dn) n_dn++;
            if (step_up && step_dn) quiet_viol++;
            if (expect_quiet && (sda_pull || cmd_valid || step_up || step_dn)) quiet_viol++;
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; waitc(HALF);
        scl_m = 1'b1; waitc(HALF);
        sda_m = 1'b0; waitc(HALF);
        scl_m = 1'b0; waitc(2);
    endtask

    task automatic bstop();
        sda_m = 1'b0; waitc(HALF);
        scl_m = 1'b1; waitc(HALF);
        sda_m = 1'b1; waitc(HALF * 2);
    endtask

    task automatic clk_bit(input logic b, output logic pulled);
        waitc(2);
        sda_m = b; waitc(HALF);
        scl_m = 1'b1; waitc(HALF / 2);
        pulled = sda_pull;
        waitc(HALF / 2);
        scl_m = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic p;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], p);
        clk_bit(1'b1, ack);
    endtask

    task automatic rd_byte(output logic [7:0] v);
        logic p;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, p);
            v[i] = ~p;
        end
        clk_bit(1'b0, p);
    endtask

    task automatic settle_and_count(input int exp_n, input string what);
        waitc(20);
        chk(cmd_q.size(), exp_n, what);
    endtask

    // three-byte write: expected command per R5
    task automatic do_write(input logic [3:0] op, input logic [1:0] sel, input logic [5:0] v,
                            input string tag);
        logic a1, a2, a3;
        cmd_q.delete();
        bstart();
        wr_byte(MY_ADDR, a1);
        wr_byte({op, sel, 2'b00}, a2);
        wr_byte({2'b00, v}, a3);
        chk({a1, a2, a3}, 3'b111, {tag, " R3 three ACKs on write"});
        bstop();
        settle_and_count(1, {tag, " R5 one command after stop"});
        if (cmd_q.size() == 1) chk(cmd_q[0], {op, sel, v}, {tag, " R5 command fields"});
    endtask

    task automatic do_xfer(input logic [3:0] op, input logic [1:0] sel, input string tag);
        logic a1, a2;
        cmd_q.delete();
        bstart();
        wr_byte(MY_ADDR, a1);
        wr_byte({op, sel, 2'b00}, a2);
        chk({a1, a2}, 2'b11, {tag, " R3 two ACKs on transfer"});
        waitc(20);
        chk(cmd_q.size(), 0, {tag, " R5 nothing before stop"});
        bstop();
        settle_and_count(1, {tag, " R5 transfer issued at stop"});
        if (cmd_q.size() == 1) chk(int'(cmd_q[0][11:6]), int'({op, sel}), {tag, " R5 op and select"});
    endtask

    task automatic do_read(input logic [3:0] op, input logic [1:0] sel,
                           input logic [5:0] expv, input string tag);
        logic a1, a2;
        logic [7:0] v;
        cmd_q.delete();
        bstart();
        wr_byte(MY_ADDR, a1);
        wr_byte({op, sel, 2'b00}, a2);
        chk({a1, a2}, 2'b11, {tag, " R3 ACKs on read"});
        rd_byte(v);
        chk(v, {2'b00, expv}, {tag, " R6 read byte"});
        waitc(4);
        chk(sda_pull, 0, {tag, " R6 line released after read"});
        bstop();
        settle_and_count(0, {tag, " R6 read issues no command"});
    endtask

    initial begin : main
        logic a1, a2, a3, p;
        int up0, dn0;
        waitc(5);
        rst = 1'b0;
        waitc(5);
        chk(sda_pull, 0, "R3 reset: line released");
        chk(cmd_valid | step_up | step_dn, 0, "R3 reset: no strobes");

        do_write(4'b1010, 2'b00, 6'h2A, "R1 write tap");
        do_write(4'b1100, 2'b11, 6'h3F, "R4 write store sel3");
        do_xfer(4'b1101, 2'b01, "R4 store1 to tap");
        do_xfer(4'b1110, 2'b11, "R4 tap to store3");
        do_read(4'b1011, 2'b10, store_val(2'b10), "R4 read store2");
        do_read(4'b1001, 2'b00, TAP_VAL, "R6 read tap");

        // foreign address (A2 differs): silent for the whole transaction
        cmd_q.delete();
        quiet_viol = 0;
        bstart();
        expect_quiet = 1'b1;
        wr_byte(8'h5D, a1);
        wr_byte(8'hA0, a2);
        wr_byte(8'h11, a3);
        chk({a1, a2, a3}, 3'b000, "R2 foreign address NACK");
        bstop();
        expect_quiet = 1'b0;
        settle_and_count(0, "R2 foreign address no command");
        chk(quiet_viol, 0, "R2 slave quiet on foreign address");

        // fixed bit 1 set
        bstart();
        wr_byte(8'h5B, a1);
        chk(a1, 0, "R2 fixed zero bit violated NACK");
        bstop();

        // unknown opcode
        cmd_q.delete();
        bstart();
        wr_byte(MY_ADDR, a1);
        wr_byte(8'h70, a2);
        chk({a1, a2}, 2'b10, "R4 unknown opcode NACK");
        wr_byte(8'h05, a3);
        chk(a3, 0, "R4 bytes after unknown opcode ignored");
        bstop();
        settle_and_count(0, "R4 unknown opcode no command");

        // restart aborts a write, then a clean transfer follows
        cmd_q.delete();
        bstart();
        wr_byte(MY_ADDR, a1);
        wr_byte(8'hC4, a2);
        bstart();
        wr_byte(MY_ADDR, a1);
        chk(a1, 1, "R8 new address phase after restart");
        wr_byte(8'hD8, a2);
        bstop();
        settle_and_count(1, "R8 aborted write dropped");
        if (cmd_q.size() == 1) chk(int'(cmd_q[0][11:6]), int'({4'b1101, 2'b10}), "R8 only the second command");

        // step stream
        cmd_q.delete();
        up0 = n_up; dn0 = n_dn;
        bstart();
        wr_byte(MY_ADDR, a1);
        wr_byte(8'h20, a2);
        chk(a2, 1, "R7 step instruction ACK");
        clk_bit(1'b1, p); clk_bit(1'b1, p); clk_bit(1'b0, p); clk_bit(1'b1, p); clk_bit(1'b0, p);
        waitc(10);
        chk(n_up - up0, 3, "R7 up steps");
        chk(n_dn - dn0, 2, "R7 down steps");
        bstop();
        waitc(20);
        chk(n_dn - dn0, 2, "R7 stop clock gives no step");
        chk(cmd_q.size(), 0, "R7 step mode issues no command");
        chk(quiet_viol, 0, "R7 step pulses exclusive");

        do_write(4'b1010, 2'b01, 6'h01, "R1 write after step mode");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule